// File: doc/BRIEF.md
# Start-up Strap Capture Sequencer

This block runs once after every reset. Three shared pads have two jobs: while the chip starts up, each one is read as a configuration strap, and once the straps are captured it drives a reference clock. All the clock outputs stay dark while the straps are read. The sequencer first waits a settle interval. It then takes repeated samples of each strap through a two-stage synchronizer. A value counts only once a run of identical samples is long enough. When every strap has settled, the decoded configuration is captured. In the same cycle every clock output is enabled and the shared pads change from input role to output role.

A hard cycle budget bounds the start-up. If the straps have not settled when the budget runs out, the most recent sample of each strap is captured and the outputs are released anyway. The decoded configuration has three fields: a spread-spectrum enable, a 48/24 select and a test mode that forces every clock output to high impedance. These fields stay frozen until the next reset, and test mode overrides every enable.

Top module: `strap_cfg_seq`

## Requirements
- R1: From reset release until the enable cycle, `clk_oe`, `strap_oe` and `strap_dir` are all zero, so every shared pad is in input role.
- R2: All bits of `strap_dir` change in a single cycle. In that same cycle, if test mode is off, all bits of `clk_oe` and `strap_oe` also change. After that no output-enable bit differs from its siblings.
- R3: With steady straps, the enable happens on rising edge SETTLE_CYC+NSAMP+1 after reset release (edge 1 is the first rising edge with `rst_n` high).
- R4: `strap_in[0]` is the spread strap. A captured low gives `cfg_ssc_en`=1 and a captured high gives 0.
- R5: `strap_in[1]` is the rate strap. A captured high gives `cfg_sel24`=1 (24 MHz) and a captured low gives 0 (48 MHz).
- R6: `strap_in[2]` is the test strap. A captured low gives `cfg_hiz`=1. `clk_oe` and `strap_oe` then stay zero until reset, while `strap_dir` still switches at the enable cycle.
- R7: A strap counts as settled only after NSAMP consecutive equal samples, and a differing sample restarts the count. A one-cycle glitch seen on the third sample delays the enable to edge SETTLE_CYC+NSAMP+4, and the steady value is the one captured.
- R8: If the straps never settle, the enable still happens on edge LIMIT_CYC, so start-up never takes more than LIMIT_CYC cycles.
- R9: After the enable, changes on `strap_in` have no effect: the cfg outputs and the enables keep their values until reset.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_in | input | 3 | Pad input values: [0] spread, [1] rate, [2] test |
| strap_dir | output | 3 | Role of each shared pad: 0 = strap input, 1 = clock output |
| strap_oe | output | 3 | Driver enable of each shared pad |
| clk_oe | output | NCLK | Enable of each dedicated clock output |
| cfg_ssc_en | output | 1 | Captured spread-spectrum enable |
| cfg_sel24 | output | 1 | Captured rate select (1 = 24 MHz) |
| cfg_hiz | output | 1 | Captured test mode (all outputs high impedance) |

## Verification
The hardest cases to reach are a restart of the agreement run and a start-up that ends on the budget rather than on settled straps. Steady straps never cause either one. The bench flips one strap for exactly one cycle on the third sampling edge, and that move pins the delayed enable edge to an exact count. It also toggles a strap on every cycle from before reset, so that agreement can never happen and only the cycle budget can release the outputs. All eight strap combinations are swept, and each one is followed by inverted straps after the enable.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

  localparam int STRAP_W = 3;
  localparam int IDX_SSC = 0;
  localparam int IDX_SEL = 1;
  localparam int IDX_TST = 2;

  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_RUN    = 2'd2
  } phase_t;

  typedef struct packed {
    logic ssc_en;
    logic sel24;
    logic hiz;
  } strap_cfg_t;

  // Pad polarity: spread and test straps are active low, rate strap active high.
  function automatic strap_cfg_t decode_straps(input logic [STRAP_W-1:0] v);
    strap_cfg_t c;
    c.ssc_en = ~v[IDX_SSC];
    c.sel24  =  v[IDX_SEL];
    c.hiz    = ~v[IDX_TST];
    return c;
  endfunction

  // Edge on which outputs release when straps are steady from reset.
  function automatic int nominal_enable_edge(input int settle, input int nsamp);
    return settle + nsamp + 1;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  // Reset to the pulled-up level of an undriven pad.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      stage2 <= '1;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/strap_filter.sv
module strap_filter #(
  parameter int W     = 3,
  parameter int NSAMP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         samp_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] val,
  output logic         agree
);
  localparam int RW = $clog2(NSAMP + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(NSAMP);

  logic [W-1:0] pin_ok;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [RW-1:0] run_len;
    logic          last;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_len <= '0;
        last    <= 1'b1;
      end else if (samp_en) begin
        if (run_len == '0 || din[i] != last) begin
          last    <= din[i];
          run_len <= RW'(1);
        end else if (run_len < RUN_MAX) begin
          run_len <= run_len + RW'(1);
        end
      end
    end

    assign pin_ok[i] = (run_len == RUN_MAX);
    assign val[i]    = last;

    assert_run_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= RUN_MAX);
    assert_restart_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && run_len != '0 && din[i] != last) |=> (run_len == RW'(1)));
  end

  assign agree = &pin_ok;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import strap_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int LIMIT_CYC  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic agree,
  output logic samp_en,
  output logic latch_evt,
  output logic running
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int TW = $clog2(LIMIT_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] LIMIT_LAST  = TW'(LIMIT_CYC - 1);
  localparam logic [TW-1:0] LIMIT_VAL   = TW'(LIMIT_CYC);

  phase_t        phase;
  logic [SW-1:0] settle_cnt;
  logic [TW-1:0] tot_cnt;
  logic          budget_out;

  assign budget_out = (tot_cnt == LIMIT_LAST);
  assign samp_en    = (phase == PH_SAMPLE);
  assign latch_evt  = (phase == PH_SAMPLE) && (agree || budget_out);
  assign running    = (phase == PH_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_SETTLE;
      settle_cnt <= '0;
      tot_cnt    <= '0;
    end else begin
      if (phase != PH_RUN) tot_cnt <= tot_cnt + TW'(1);
      case (phase)
        PH_SETTLE: begin
          settle_cnt <= settle_cnt + SW'(1);
          if (settle_cnt == SETTLE_LAST) phase <= PH_SAMPLE;
        end
        PH_SAMPLE: if (latch_evt) phase <= PH_RUN;
        default:   phase <= PH_RUN;
      endcase
    end
  end

  assert_startup_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_RUN) |-> (tot_cnt < LIMIT_VAL));
  assert_run_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
  assert_latch_enters_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> running);
endmodule

// File: rtl/strap_cfg_seq.sv
module strap_cfg_seq
  import strap_seq_pkg::*;
#(
  parameter int NCLK       = 9,
  parameter int SETTLE_CYC = 16,
  parameter int NSAMP      = 4,
  parameter int LIMIT_CYC  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_in,
  output logic [2:0]        strap_dir,
  output logic [2:0]        strap_oe,
  output logic [NCLK-1:0]   clk_oe,
  output logic              cfg_ssc_en,
  output logic              cfg_sel24,
  output logic              cfg_hiz
);
  logic [STRAP_W-1:0] sync_val;
  logic [STRAP_W-1:0] filt_val;
  logic               agree;
  logic               samp_en;
  logic               latch_evt;
  logic               running;
  strap_cfg_t         cfg_q;
  logic               drive_ok;

  strap_sync #(.W(STRAP_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (strap_in),
    .dout (sync_val)
  );

  strap_filter #(.W(STRAP_W), .NSAMP(NSAMP)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .samp_en(samp_en),
    .din    (sync_val),
    .val    (filt_val),
    .agree  (agree)
  );

  seq_ctrl #(.SETTLE_CYC(SETTLE_CYC), .LIMIT_CYC(LIMIT_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .agree    (agree),
    .samp_en  (samp_en),
    .latch_evt(latch_evt),
    .running  (running)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (latch_evt) cfg_q <= decode_straps(filt_val);
  end

  assign drive_ok   = running & ~cfg_q.hiz;
  assign strap_dir  = {STRAP_W{running}};
  assign strap_oe   = strap_dir & {STRAP_W{~cfg_q.hiz}};
  assign clk_oe     = {NCLK{drive_ok}};
  assign cfg_ssc_en = cfg_q.ssc_en;
  assign cfg_sel24  = cfg_q.sel24;
  assign cfg_hiz    = cfg_q.hiz;

  assert_dark_startup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (clk_oe == '0 && strap_oe == '0 && strap_dir == '0));
  assert_oe_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe == '0 || &clk_oe) && (strap_dir == '0 || &strap_dir));
  assert_dir_after_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_dir[0]) |-> $past(latch_evt));
  assert_hiz_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.hiz |-> (clk_oe == '0 && strap_oe == '0));
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(cfg_q));
endmodule

// File: tb/tb_strap_cfg_seq.sv
module tb_strap_cfg_seq;
  localparam int NCLK = 9;
  localparam int S    = 4;
  localparam int N    = 3;
  localparam int L    = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      straps = 3'b111;
  logic            tog_en = 1'b0;
  logic            tog = 1'b0;
  logic [2:0]      strap_in;
  logic [2:0]      strap_dir;
  logic [2:0]      strap_oe;
  logic [NCLK-1:0] clk_oe;
  logic            cfg_ssc_en, cfg_sel24, cfg_hiz;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) if (tog_en) tog <= ~tog;
  assign strap_in = straps ^ {2'b00, tog};

  strap_cfg_seq #(.NCLK(NCLK), .SETTLE_CYC(S), .NSAMP(N), .LIMIT_CYC(L)) dut (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .strap_dir(strap_dir),
    .strap_oe(strap_oe), .clk_oe(clk_oe), .cfg_ssc_en(cfg_ssc_en),
    .cfg_sel24(cfg_sel24), .cfg_hiz(cfg_hiz)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] v);
    rst_n = 1'b0;
    straps = v;
    @(negedge clk);
    @(negedge clk);
    chk({strap_dir, strap_oe, clk_oe, cfg_ssc_en, cfg_sel24, cfg_hiz} == '0,
        "R10 reset outputs", int'(clk_oe), 0);
    rst_n = 1'b1;
  endtask

  // Observe after each rising edge; optionally flip one strap for one cycle after edge gk.
  task automatic wait_enable(input int gk, input int gbit, output int k_en);
    k_en = -1;
    for (int k = 1; k <= L + 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (strap_dir != 3'b000) begin
        k_en = k;
        break;
      end
      chk(clk_oe == '0 && strap_oe == 3'b000, "R1 dark start-up", int'(clk_oe), 0);
      if (gk != 0 && k == gk)     straps[gbit] = ~straps[gbit];
      if (gk != 0 && k == gk + 1) straps[gbit] = ~straps[gbit];
    end
  endtask

  task automatic check_released(input logic [2:0] v, input string tag);
    bit exp_hiz;
    logic [NCLK-1:0] exp_oe;
    exp_hiz = (v[2] == 1'b0);
    exp_oe  = exp_hiz ? '0 : '1;
    chk(strap_dir == 3'b111, {"R2 dir ", tag}, int'(strap_dir), 7);
    chk(clk_oe == exp_oe, {"R2 R6 clk_oe ", tag}, int'(clk_oe), int'(exp_oe));
    chk(strap_oe == (exp_hiz ? 3'b000 : 3'b111), {"R6 strap_oe ", tag},
        int'(strap_oe), exp_hiz ? 0 : 7);
    chk(cfg_ssc_en == (v[0] == 1'b0), {"R4 ssc ", tag}, int'(cfg_ssc_en), int'(v[0] == 1'b0));
    chk(cfg_sel24 == v[1], {"R5 sel24 ", tag}, int'(cfg_sel24), int'(v[1]));
    chk(cfg_hiz == exp_hiz, {"R6 hiz ", tag}, int'(cfg_hiz), int'(exp_hiz));
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog: actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int ke;
    // Exhaustive sweep of strap combinations (R3, R4, R5, R6, R9).
    for (int c = 0; c < 8; c++) begin
      do_reset(3'(c));
      wait_enable(0, 0, ke);
      chk(ke == S + N + 1, "R3 enable edge", ke, S + N + 1);
      check_released(3'(c), "sweep");
      straps = ~3'(c);
      for (int i = 0; i < 6; i++) @(negedge clk);
      check_released(3'(c), "R9 after strap change");
    end

    // One-cycle glitch seen on the third sample (R7).
    for (int b = 0; b < 3; b++) begin
      do_reset(3'b110);
      wait_enable(S, b, ke);
      chk(ke == S + N + 4, "R7 glitch enable edge", ke, S + N + 4);
      check_released(3'b110, "R7 glitch value");
    end

    // Strap that never settles: only the budget releases (R8).
    tog_en = 1'b1;
    do_reset(3'b110);
    wait_enable(0, 0, ke);
    chk(ke == L, "R8 budget enable edge", ke, L);
    chk(cfg_sel24 == 1'b1 && cfg_hiz == 1'b0, "R8 steady straps captured",
        int'({cfg_sel24, cfg_hiz}), 2);
    chk(clk_oe == '1, "R8 outputs released", int'(clk_oe), (1 << NCLK) - 1);
    tog_en = 1'b0;

    // Reset during run returns everything to zero (R10).
    rst_n = 1'b0;
    #1;
    chk({strap_dir, strap_oe, clk_oe, cfg_ssc_en, cfg_sel24, cfg_hiz} == '0,
        "R10 async reset", int'(clk_oe), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule